// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the clocked control front end of a small synchronous SRAM that supports four-beat bursts. On every rising clock edge it samples three chip selects, a sleep request, two competing address strobes (one from a processor side, one from a memory-controller side), a burst-advance input and the write controls. It then picks one operation: deselect, sleep, start a burst at the external address, step the burst to its next address, or hold the burst at its current address. Each operation that touches the array is either a read or a write.

Writes are merged byte by byte into the addressed word. Read data is registered and shows up on the data bus in the cycle after the address is taken. The bus is split for a pad cell into a data-out vector and a drive enable. The enable follows the active-low output enable combinationally and is forced off whenever the inputs currently being presented decode to a write. The burst counter stays inside an aligned group of four words and steps through it in either linear or interleaved order.

Top module: `sburst_ctrl`

## Requirements
- R1: The internal write condition is true when `gw_n` is low, or when `bwe_n` is low and at least one bit of `lane_n` is low. In every other case a cycle that would write becomes a read.
- R2: A high `sleep` overrides all other inputs. No lane is written, the burst is cleared, and `dq_oe` is low after that edge.
- R3: A burst starts only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. An accepted strobe that arrives without this selection gives a deselect: nothing is written and `dq_oe` is low after the edge.
- R4: A low `pstb_n` with `sel_a_n` low starts a read burst at `addr`, whatever `gw_n`, `bwe_n` and `lane_n` show.
- R5: A low `cstb_n` with `pstb_n` high and the chip selected starts a burst at `addr`. It is a write when the R1 condition holds and a read otherwise.
- R6: While `sel_a_n` is high, `pstb_n` is ignored. A low `cstb_n` then deselects, and a high `cstb_n` lets the burst step or hold.
- R7: With no accepted strobe, `adv_n`=0 steps to the next burst address and `adv_n`=1 holds the current address. Both can read or write. The two low address bits run start+count mod 4 when `ilv_mode`=0, and start XOR count when `ilv_mode`=1. The upper bits stay fixed. The order is latched when the burst starts.
- R8: On a write, lane i (bits 8i+7..8i) is updated only when `lane_n[i]` is low. When `gw_n` is low, all four lanes are written.
- R9: After a read edge, `dq_out` holds the addressed word, and `dq_oe` is high exactly while `oe_n` is low. `oe_n` acts without a clock edge.
- R10: `dq_oe` is low in any cycle whose current inputs decode to a write.
- R11: A step or hold request with no burst active (after reset, deselect or sleep) is treated as a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a_n | input | 1 | Primary chip select, active low; gates the processor strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| sleep | input | 1 | Power-down request, active high |
| pstb_n | input | 1 | Processor-side address strobe, active low, always reads |
| cstb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Write all lanes, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| lane_n | input | 4 | Per-lane write selects, active low |
| ilv_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | 6 | External word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | 32 | Write data from the pad |
| dq_out | output | 32 | Read data to the pad |
| dq_oe | output | 1 | Pad drive enable |

## Verification
Two things can land in the same cycle: the output driver is still presenting the previous read while a write is being set up on the inputs. The bench starts a read with `oe_n` low and confirms that the bus drives. It then applies burst-step write controls without a clock edge and expects `dq_oe` to drop at once. After the edge it reads the word back to confirm that the write landed at the stepped address. A second overlap is a processor strobe that arrives together with active write controls. Here the bench expects read data and an untouched array.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [2:0] {
    OP_DESEL = 3'd0,
    OP_SLEEP = 3'd1,
    OP_BEGIN = 3'd2,
    OP_NEXT  = 3'd3,
    OP_HOLD  = 3'd4
  } op_e;

  // low two address bits of a beat within the aligned group of four
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] cnt,
                                          input logic       ilv);
    return ilv ? (start ^ cnt) : (start + cnt);
  endfunction

  function automatic logic touches_array(input op_e op);
    return (op == OP_BEGIN) || (op == OP_NEXT) || (op == OP_HOLD);
  endfunction

endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
#(
  parameter int NLANE = 4
) (
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             sleep,
  input  logic             pstb_n,
  input  logic             cstb_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [NLANE-1:0] lane_n,
  input  logic             burst_act,
  output op_e              op,
  output logic             is_wr,
  output logic [NLANE-1:0] lane_we
);

  logic wr_int;
  logic selected;
  logic p_take;

  assign wr_int   = !gw_n || (!bwe_n && !(&lane_n));
  assign selected = !sel_a_n && sel_b && !sel_c_n;
  assign p_take   = !pstb_n && !sel_a_n;

  always_comb begin
    op    = OP_DESEL;
    is_wr = 1'b0;
    if (sleep) begin
      op = OP_SLEEP;
    end else if (p_take) begin
      op = selected ? OP_BEGIN : OP_DESEL;
    end else if (!cstb_n) begin
      op    = selected ? OP_BEGIN : OP_DESEL;
      is_wr = selected && wr_int;
    end else if (burst_act) begin
      op    = adv_n ? OP_HOLD : OP_NEXT;
      is_wr = wr_int;
    end
  end

  always_comb begin
    if (!is_wr)     lane_we = '0;
    else if (!gw_n) lane_we = '1;
    else            lane_we = ~lane_n;
  end

endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
  import sbs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic [AW-1:0] addr,
  input  logic          ilv_in,
  output logic [AW-1:0] eff_addr,
  output logic          burst_act
);

  localparam int HI_W = AW - 2;

  logic [HI_W-1:0] base_hi;
  logic [1:0]      start;
  logic [1:0]      cnt;
  logic            ilv;
  logic [1:0]      cnt_nx;

  assign cnt_nx = cnt + 2'd1;

  always_comb begin
    case (op)
      OP_NEXT: eff_addr = {base_hi, beat_low(start, cnt_nx, ilv)};
      OP_HOLD: eff_addr = {base_hi, beat_low(start, cnt, ilv)};
      default: eff_addr = addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi   <= '0;
      start     <= '0;
      cnt       <= '0;
      ilv       <= 1'b0;
      burst_act <= 1'b0;
    end else begin
      case (op)
        OP_BEGIN: begin
          base_hi   <= addr[AW-1:2];
          start     <= addr[1:0];
          cnt       <= '0;
          ilv       <= ilv_in;
          burst_act <= 1'b1;
        end
        OP_NEXT:  cnt <= cnt_nx;
        OP_HOLD:  cnt <= cnt;
        default:  burst_act <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int AW    = 6,
  parameter int NLANE = 4,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NLANE-1:0]    lane_we,
  input  logic                rd_en,
  input  logic [AW-1:0]       addr,
  input  logic [NLANE*LW-1:0] wdata,
  output logic [NLANE*LW-1:0] rdata,
  output logic                rvalid
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[addr] <= wdata[g*LW +: LW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata[g*LW +: LW] <= '0;
      else if (rd_en) rdata[g*LW +: LW] <= mem[addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rd_en;
  end

endmodule

// File: rtl/sburst_ctrl.sv
module sburst_ctrl
  import sbs_pkg::*;
#(
  parameter int AW    = 6,
  parameter int NLANE = 4,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_a_n,
  input  logic                sel_b,
  input  logic                sel_c_n,
  input  logic                sleep,
  input  logic                pstb_n,
  input  logic                cstb_n,
  input  logic                adv_n,
  input  logic                gw_n,
  input  logic                bwe_n,
  input  logic [NLANE-1:0]    lane_n,
  input  logic                ilv_mode,
  input  logic [AW-1:0]       addr,
  input  logic                oe_n,
  input  logic [NLANE*LW-1:0] dq_in,
  output logic [NLANE*LW-1:0] dq_out,
  output logic                dq_oe
);

  localparam int DW = NLANE * LW;

  op_e              op_now;
  logic             wr_now;
  logic [NLANE-1:0] lane_we;
  logic [AW-1:0]    eff_addr;
  logic             burst_act;
  logic             rd_now;
  logic             rvalid;
  logic [DW-1:0]    rdata;

  sbs_decode #(.NLANE(NLANE)) u_dec (
    .sel_a_n  (sel_a_n),
    .sel_b    (sel_b),
    .sel_c_n  (sel_c_n),
    .sleep    (sleep),
    .pstb_n   (pstb_n),
    .cstb_n   (cstb_n),
    .adv_n    (adv_n),
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .lane_n   (lane_n),
    .burst_act(burst_act),
    .op       (op_now),
    .is_wr    (wr_now),
    .lane_we  (lane_we)
  );

  sbs_burst_ctr #(.AW(AW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op_now),
    .addr     (addr),
    .ilv_in   (ilv_mode),
    .eff_addr (eff_addr),
    .burst_act(burst_act)
  );

  assign rd_now = touches_array(op_now) && !wr_now;

  sbs_array #(.AW(AW), .NLANE(NLANE), .LW(LW)) u_arr (
    .clk    (clk),
    .rst_n  (rst_n),
    .lane_we(lane_we),
    .rd_en  (rd_now),
    .addr   (eff_addr),
    .wdata  (dq_in),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

  assign dq_out = rdata;
  assign dq_oe  = rvalid && !oe_n && !wr_now;

endmodule

// File: rtl/sbs_checks.sv
module sbs_checks
  import sbs_pkg::*;
#(
  parameter int AW    = 6,
  parameter int NLANE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep,
  input logic             pstb_n,
  input logic             cstb_n,
  input logic             sel_a_n,
  input logic             sel_b,
  input logic             sel_c_n,
  input logic             oe_n,
  input op_e              op,
  input logic             is_wr,
  input logic [NLANE-1:0] lane_we,
  input logic [AW-1:0]    eff_addr,
  input logic             rvalid,
  input logic             dq_oe
);

  logic sel_ok;
  logic strobe_seen;
  assign sel_ok      = !sel_a_n && sel_b && !sel_c_n;
  assign strobe_seen = !cstb_n || (!pstb_n && !sel_a_n);

  a_r2_sleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (lane_we == '0));

  a_r2_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rvalid);

  a_r3_unselected_desel: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && strobe_seen && !sel_ok) |-> (op == OP_DESEL && lane_we == '0));

  a_r4_pstb_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !pstb_n && !sel_a_n) |-> (lane_we == '0));

  a_r7_hold_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |-> (eff_addr == $past(eff_addr)));

  a_r9_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (touches_array(op) && !is_wr) |=> rvalid);

  a_r9_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  a_r10_write_masks_bus: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |-> !dq_oe);

endmodule

bind sburst_ctrl sbs_checks #(.AW(AW), .NLANE(NLANE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sleep   (sleep),
  .pstb_n  (pstb_n),
  .cstb_n  (cstb_n),
  .sel_a_n (sel_a_n),
  .sel_b   (sel_b),
  .sel_c_n (sel_c_n),
  .oe_n    (oe_n),
  .op      (op_now),
  .is_wr   (wr_now),
  .lane_we (lane_we),
  .eff_addr(eff_addr),
  .rvalid  (rvalid),
  .dq_oe   (dq_oe)
);

// File: tb/sburst_ctrl_bench.sv
module sburst_ctrl_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0, sleep = 1'b0;
  logic        pstb_n = 1'b1, cstb_n = 1'b1, adv_n = 1'b1;
  logic        gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]  lane_n = 4'hF;
  logic        ilv_mode = 1'b0;
  logic [5:0]  addr = '0;
  logic        oe_n = 1'b0;
  logic [31:0] dq_in = '0;
  logic [31:0] dq_out;
  logic        dq_oe;

  logic [31:0] ref_mem [64];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sburst_ctrl u_sburst_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .sleep(sleep), .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .lane_n(lane_n), .ilv_mode(ilv_mode), .addr(addr), .oe_n(oe_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // set controls for one cycle; selection left as is
  task automatic ctl(input bit ps, input bit cs, input bit adv, input bit gw,
                     input bit bwe, input logic [3:0] ln, input logic [5:0] a,
                     input logic [31:0] d);
    pstb_n = ps; cstb_n = cs; adv_n = adv; gw_n = gw; bwe_n = bwe;
    lane_n = ln; addr = a; dq_in = d;
  endtask

  task automatic quiet();
    ctl(1, 1, 1, 1, 1, 4'hF, 6'd0, 32'h0);
    sel_a_n = 0; sel_b = 1; sel_c_n = 0; sleep = 0; oe_n = 0;
  endtask

  task automatic end_burst();
    sel_b = 0; ctl(1, 0, 1, 1, 1, 4'hF, 6'd0, 32'h0); tick();
    sel_b = 1; quiet();
  endtask

  task automatic expect_read(input string tag, input int a);
    chk({tag, " oe"}, {31'd0, dq_oe}, 32'd1);
    chk({tag, " data"}, dq_out, ref_mem[a]);
  endtask

  task automatic t_reset();
    chk("R9 reset oe", {31'd0, dq_oe}, 32'd0);
    tick();
    chk("R11 step with no burst", {31'd0, dq_oe}, 32'd0);
  endtask

  // R5 R7 R8: linear burst writes at 5 -> 5,6,7,4 then R4 read back
  task automatic t_linear();
    int seq [4] = '{5, 6, 7, 4};
    ilv_mode = 0;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w = 32'hA000_0000 + 32'(i * 32'h0101);
      if (i == 0) ctl(1, 0, 1, 0, 1, 4'hF, 6'd5, w);
      else        ctl(1, 1, 0, 0, 1, 4'hF, 6'd0, w);
      ref_mem[seq[i]] = w;
      tick();
    end
    ctl(0, 1, 1, 0, 0, 4'h0, 6'd5, 32'hDEAD_BEEF);  // R4 write controls ignored
    tick();
    expect_read("R4 pstb read", 5);
    for (int i = 1; i < 5; i++) begin
      ctl(1, 1, 0, 1, 1, 4'hF, 6'd0, 32'h0);
      tick();
      expect_read("R7 linear step", seq[i % 4]);
    end
    end_burst();
  endtask

  // R7 interleaved: write from 10 -> 10,11,8,9; read from 9 -> 9,8,11,10
  task automatic t_interleave();
    int wseq [4] = '{10, 11, 8, 9};
    int rseq [4] = '{9, 8, 11, 10};
    ilv_mode = 1;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w = 32'hB100_0000 + 32'(i * 32'h11);
      if (i == 0) ctl(1, 0, 1, 0, 1, 4'hF, 6'd10, w);
      else        ctl(1, 1, 0, 0, 1, 4'hF, 6'd0, w);
      ref_mem[wseq[i]] = w;
      tick();
    end
    ctl(1, 0, 1, 1, 1, 4'hF, 6'd9, 32'h0);
    tick();
    expect_read("R7 ilv begin", 9);
    for (int i = 1; i < 4; i++) begin
      ctl(1, 1, 0, 1, 1, 4'hF, 6'd0, 32'h0);
      tick();
      expect_read("R7 ilv step", rseq[i]);
    end
    ilv_mode = 0;
    end_burst();
  endtask

  // R7 hold: read hold keeps address; write hold overwrites same word
  task automatic t_suspend();
    ctl(1, 0, 1, 1, 1, 4'hF, 6'd8, 32'h0); tick();
    ctl(1, 1, 1, 1, 1, 4'hF, 6'd0, 32'h0); tick();
    expect_read("R7 hold read", 8);
    ctl(1, 1, 0, 1, 1, 4'hF, 6'd0, 32'h0); tick();
    expect_read("R7 step after hold", 9);
    ctl(1, 0, 1, 0, 1, 4'hF, 6'd16, 32'h1616_0001); tick();
    ctl(1, 1, 1, 0, 1, 4'hF, 6'd0, 32'h1616_0002); tick();
    ref_mem[16] = 32'h1616_0002;
    ctl(1, 0, 1, 1, 1, 4'hF, 6'd16, 32'h0); tick();
    expect_read("R7 hold write", 16);
    end_burst();
  endtask

  // R8 lanes, R1 write condition
  task automatic t_bytes();
    ctl(1, 0, 1, 0, 1, 4'hF, 6'd20, 32'h1122_3344); tick();
    ctl(1, 0, 1, 1, 0, 4'b1010, 6'd20, 32'hAABB_CCDD); tick();
    ref_mem[20] = 32'h11BB_33DD;
    ctl(1, 0, 1, 1, 0, 4'hF, 6'd20, 32'hFFFF_FFFF); tick();
    expect_read("R1 bwe without lanes reads", 20);
    chk("R8 lane merge", dq_out, 32'h11BB_33DD);
    ctl(1, 0, 1, 1, 1, 4'h0, 6'd20, 32'hFFFF_FFFF); tick();
    expect_read("R1 lanes without bwe reads", 20);
    end_burst();
  endtask

  // R3 unselected strobes, R11 step with no burst
  task automatic t_deselect();
    ctl(1, 0, 1, 1, 1, 4'hF, 6'd20, 32'h0); tick();
    sel_b = 0; ctl(1, 0, 1, 0, 1, 4'hF, 6'd20, 32'h5555_5555); tick();
    chk("R3 cs unselected", {31'd0, dq_oe}, 32'd0);
    sel_b = 1; ctl(1, 1, 0, 0, 1, 4'hF, 6'd0, 32'h6666_6666); tick();
    chk("R11 step after deselect", {31'd0, dq_oe}, 32'd0);
    sel_c_n = 1; ctl(0, 1, 1, 1, 1, 4'hF, 6'd20, 32'h0); tick();
    chk("R3 ps unselected", {31'd0, dq_oe}, 32'd0);
    sel_c_n = 0; ctl(1, 0, 1, 1, 1, 4'hF, 6'd20, 32'h0); tick();
    expect_read("R3 no write on deselect", 20);
    end_burst();
  endtask

  // R6 processor strobe ignored with sel_a_n high
  task automatic t_ce1_high();
    ctl(1, 0, 1, 1, 1, 4'hF, 6'd4, 32'h0); tick();
    sel_a_n = 1; ctl(0, 1, 0, 1, 1, 4'hF, 6'd40, 32'h0); tick();
    expect_read("R6 ps ignored, steps", 5);
    ctl(0, 0, 1, 1, 1, 4'hF, 6'd40, 32'h0); tick();
    chk("R6 cs deselects", {31'd0, dq_oe}, 32'd0);
    quiet();
  endtask

  // R2 sleep
  task automatic t_sleep();
    ctl(1, 0, 1, 1, 1, 4'hF, 6'd5, 32'h0); tick();
    sleep = 1; ctl(1, 0, 1, 0, 1, 4'hF, 6'd5, 32'h7777_7777); tick();
    chk("R2 sleep tristate", {31'd0, dq_oe}, 32'd0);
    sleep = 0; ctl(1, 1, 0, 0, 1, 4'hF, 6'd0, 32'h8888_8888); tick();
    chk("R2 burst cleared", {31'd0, dq_oe}, 32'd0);
    ctl(1, 0, 1, 1, 1, 4'hF, 6'd5, 32'h0); tick();
    expect_read("R2 no write in sleep", 5);
    end_burst();
  endtask

  // R9 async output enable, R10 write masks the bus
  task automatic t_oe();
    oe_n = 1; ctl(1, 0, 1, 1, 1, 4'hF, 6'd6, 32'h0); tick();
    chk("R9 oe high", {31'd0, dq_oe}, 32'd0);
    oe_n = 0; #1;
    expect_read("R9 oe async", 6);
    ctl(1, 1, 0, 0, 1, 4'hF, 6'd0, 32'hC0DE_0007); #1;
    chk("R10 write masks bus", {31'd0, dq_oe}, 32'd0);
    ref_mem[7] = 32'hC0DE_0007;
    tick();
    ctl(1, 0, 1, 1, 1, 4'hF, 6'd7, 32'h0); tick();
    expect_read("R10 write landed", 7);
    end_burst();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    repeat (2) @(posedge clk);
    #2;
    rst_n = 1;
    t_reset();
    t_linear();
    t_interleave();
    t_suspend();
    t_bytes();
    t_deselect();
    t_ce1_high();
    t_sleep();
    t_oe();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule